// File: doc/BRIEF.md
# Memory Window Base Register with Size Discovery

This block is one 32-bit memory base register for a configuration-space target, combined with the address decoder it controls. The window size is fixed when the block is elaborated. It must be a power of two and no smaller than 4 KB. Only the register bits at or above log2(SIZE) hold a base address, so the number of bits the host can write depends on the window size.

Bring-up follows three steps:

1. The host writes all ones to the register and reads it back. The ones that survive show which bits are writable, and the host takes the size as the two's complement of that value with the attribute bits masked off.
2. The host writes a base address aligned to the window size.
3. The host turns decoding on.

From then on, each valid 32-bit request address whose upper bits equal the stored base gives a registered hit, together with the offset of that address inside the window. Elaborating with a size that is not a power of two, or that is below 4096, stops with an elaboration error.

Top module: `membar_window`

## Requirements
- R1: A configuration write with all four byte enables set loads write-data bits 31:log2(SIZE) into the base field. The register reads back the new value from the next cycle. The register keeps its value in cycles with no write.
- R2: Bits log2(SIZE)-1 down to 12 always read as zero, whatever value is written to them.
- R3: Bits 11:2 always read as zero. Bits 1:0 always read the ATTR parameter (default 2'b00, a 32-bit memory window), and writes to them have no effect.
- R4: After 0xFFFF_F000 is written, the readback equals ~(SIZE-1). For the default 256 KB window this is 0xFFFC_0000, and the two's complement of the value with bits 1:0 cleared equals SIZE.
- R5: Byte enable cfg_be[k] allows the write of bits 8k+7:8k. A writable bit whose lane is not enabled keeps its value.
- R6: Reset clears the base field and the decode enable. After reset the readback equals ATTR and hit is 0.
- R7: No hit occurs while the decode enable register is 0 or req_valid is 0. The enable register samples dec_en at each clock edge, so a change on dec_en affects lookups presented one cycle later.
- R8: A valid lookup with decoding on, where req_addr[31:log2(SIZE)] equals the stored base, raises hit one cycle later. In that same cycle hit_offset equals req_addr[log2(SIZE)-1:0]. Any other address gives hit = 0.
- R9: When a configuration write and a lookup fall in the same cycle, the lookup is compared against the base held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for the configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Register readback |
| dec_en | input | 1 | Decode-enable control bit, sampled into a register |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 32 | Request address to decode |
| hit | output | 1 | Registered window hit |
| hit_offset | output | LOG2_SIZE | Registered offset inside the window |

## Verification
A base rewrite and an address lookup can happen in the same clock cycle. The bench provokes this by driving a new base on the write port while it presents an address that matches only the old base. It expects hit = 1 on the following edge, because the comparison uses the base held before the write. It then checks that the same address now misses and that an address inside the new window hits with the correct offset. Turning decoding off and presenting a lookup are checked the same way, using the one-cycle delay of the enable register.

// File: rtl/membar_pkg.sv
package membar_pkg;

  localparam int unsigned WORD_W   = 32;
  localparam int unsigned MIN_LG   = 12;

  // Power-of-two window between 4 KB and 2 GB.
  function automatic bit size_ok(longint unsigned size);
    return (size >= 64'd4096) && (size <= 64'h8000_0000) &&
           ((size & (size - 64'd1)) == 64'd0);
  endfunction

  // Bits that hold the base address for a window of 2**lg bytes.
  function automatic logic [31:0] base_mask(int unsigned lg);
    return 32'hFFFF_FFFF << lg;
  endfunction

  // Expand per-byte enables into a per-bit mask.
  function automatic logic [31:0] lane_mask(logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) begin
      m[8*k +: 8] = {8{be[k]}};
    end
    return m;
  endfunction

  // Merge write data into the held word under a per-bit mask.
  function automatic logic [31:0] merge(logic [31:0] held, logic [31:0] wdata,
                                        logic [31:0] m);
    return (held & ~m) | (wdata & m);
  endfunction

  // Readback view: base bits, zeros, fixed attribute bits.
  function automatic logic [31:0] readback(logic [31:0] word, int unsigned lg,
                                           logic [1:0] attr);
    return (word & base_mask(lg)) | {30'd0, attr};
  endfunction

  // Naturally aligned window: compare only the upper bits.
  function automatic logic window_match(logic [31:0] addr, logic [31:0] base,
                                        int unsigned lg);
    return ((addr ^ base) & base_mask(lg)) == 32'd0;
  endfunction

endpackage

// File: rtl/membar_store.sv
module membar_store #(
  parameter int unsigned LG   = 18,
  parameter logic [1:0]  ATTR = 2'b00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [3:0]  cfg_be,
  input  logic [31:0] cfg_wdata,
  input  logic        dec_en,
  output logic [31:0] base_word,
  output logic        en_q,
  output logic [31:0] cfg_rdata
);
  localparam logic [31:0] WMASK = membar_pkg::base_mask(LG);

  logic [31:0] word_q;
  logic [31:0] upd_mask;

  // Only writable bits inside enabled lanes may change.
  assign upd_mask = membar_pkg::lane_mask(cfg_be) & WMASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      en_q   <= 1'b0;
    end else begin
      en_q <= dec_en;
      if (cfg_wr) begin
        word_q <= membar_pkg::merge(word_q, cfg_wdata, upd_mask);
      end
    end
  end

  assign base_word = word_q & WMASK;
  assign cfg_rdata = membar_pkg::readback(word_q, LG, ATTR);

endmodule

// File: rtl/membar_decode.sv
module membar_decode #(
  parameter int unsigned LG = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [31:0]   req_addr,
  input  logic [31:0]   base_word,
  input  logic          en,
  output logic          addr_match,
  output logic          hit_q,
  output logic [LG-1:0] offset_q
);

  assign addr_match = membar_pkg::window_match(req_addr, base_word, LG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q    <= 1'b0;
      offset_q <= '0;
    end else begin
      hit_q <= req_valid && en && addr_match;
      if (req_valid) begin
        offset_q <= req_addr[LG-1:0];
      end
    end
  end

endmodule

// File: rtl/membar_window.sv
module membar_window #(
  parameter int unsigned SIZE = 262144,
  parameter logic [1:0]  ATTR = 2'b00,
  localparam int unsigned LOG2_SIZE = $clog2(SIZE)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [3:0]           cfg_be,
  input  logic [31:0]          cfg_wdata,
  output logic [31:0]          cfg_rdata,
  input  logic                 dec_en,
  input  logic                 req_valid,
  input  logic [31:0]          req_addr,
  output logic                 hit,
  output logic [LOG2_SIZE-1:0] hit_offset
);

  if (!membar_pkg::size_ok(64'(SIZE))) begin : g_bad_size
    $error("membar_window: SIZE must be a power of two in 4096..2**31");
  end

  // Named internal events, visible to the bound checker.
  logic [31:0] base_word;
  logic        decode_live;
  logic        addr_match;

  membar_store #(
    .LG   (LOG2_SIZE),
    .ATTR (ATTR)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .dec_en    (dec_en),
    .base_word (base_word),
    .en_q      (decode_live),
    .cfg_rdata (cfg_rdata)
  );

  membar_decode #(
    .LG (LOG2_SIZE)
  ) u_decode (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .base_word  (base_word),
    .en         (decode_live),
    .addr_match (addr_match),
    .hit_q      (hit),
    .offset_q   (hit_offset)
  );

endmodule

// File: rtl/membar_window_chk.sv
module membar_window_chk #(
  parameter int unsigned LG = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_wr,
  input logic [3:0]    cfg_be,
  input logic [31:0]   cfg_wdata,
  input logic [31:0]   cfg_rdata,
  input logic          decode_live,
  input logic          addr_match,
  input logic          req_valid,
  input logic [31:0]   req_addr,
  input logic          hit,
  input logic [LG-1:0] hit_offset
);
  localparam logic [31:0] WMASK = membar_pkg::base_mask(LG);

  AST_FULL_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_be == 4'hF) |=> ((cfg_rdata & WMASK) == ($past(cfg_wdata) & WMASK))); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata)); // R1

  AST_LOW_BITS_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_rdata[LG-1:0] == $past(cfg_rdata[LG-1:0]))); // R3

  AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (((cfg_rdata ^ $past(cfg_rdata)) & ~membar_pkg::lane_mask($past(cfg_be))) == 32'd0)); // R5

  AST_HIT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ($past(decode_live) && $past(req_valid))); // R7

  AST_HIT_OLD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ((($past(req_addr) ^ $past(cfg_rdata)) & WMASK) == 32'd0)); // R9

  AST_MATCH_GIVES_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && decode_live && addr_match) |=> hit); // R8

  AST_OFFSET_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_offset == $past(req_addr[LG-1:0]))); // R8

endmodule

bind membar_window membar_window_chk #(.LG(LOG2_SIZE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr      (cfg_wr),
  .cfg_be      (cfg_be),
  .cfg_wdata   (cfg_wdata),
  .cfg_rdata   (cfg_rdata),
  .decode_live (decode_live),
  .addr_match  (addr_match),
  .req_valid   (req_valid),
  .req_addr    (req_addr),
  .hit         (hit),
  .hit_offset  (hit_offset)
);

// File: tb/membar_window_bench.sv
module membar_window_bench;
  localparam int unsigned SIZE = 262144;
  localparam int unsigned LG   = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [3:0]    cfg_be = 4'h0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          dec_en = 1'b0;
  logic          req_valid = 1'b0;
  logic [31:0]   req_addr = '0;
  logic          hit;
  logic [LG-1:0] hit_offset;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;  // bench's own view of the register

  always #5 clk = ~clk;

  membar_window #(.SIZE(SIZE)) u_membar_window (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_en(dec_en),
    .req_valid(req_valid), .req_addr(req_addr), .hit(hit),
    .hit_offset(hit_offset)
  );

  // Writable bits: everything at or above the window size.
  function automatic logic [31:0] keep_bits();
    return ~(32'(SIZE) - 32'd1);
  endfunction

  function automatic logic [31:0] lanes(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cfg_write(logic [31:0] data, logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = data; cfg_be = be;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0;
    model = (model & ~(lanes(be) & keep_bits())) | (data & lanes(be) & keep_bits());
  endtask

  task automatic lookup(logic valid, logic [31:0] addr);
    @(negedge clk);
    req_valid = valid; req_addr = addr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic set_enable(logic v);
    @(negedge clk);
    dec_en = v;
    @(posedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    dec_en = 1'b0;
    model = '0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R6 readback after reset", cfg_rdata, 32'h0);
    check("R6 hit after reset", {31'd0, hit}, 32'd0);
    lookup(1'b1, 32'h0000_0010);  // base 0 matches, but decode is off
    check("R6 no hit before enable", {31'd0, hit}, 32'd0);
  endtask

  task automatic t_sizing();
    logic [31:0] sz;
    cfg_write(32'hFFFF_F000, 4'hF);
    check("R4 sizing readback", cfg_rdata, 32'hFFFC_0000);
    sz = ~(cfg_rdata & ~32'h3) + 32'd1;
    check("R4 derived size", sz, 32'(SIZE));
    check("R1 readback matches write", cfg_rdata, model);
  endtask

  task automatic t_read_only();
    cfg_write(32'h0003_FFFF, 4'hF);
    check("R2 bits 17:12 read zero", cfg_rdata & 32'h0003_F000, 32'h0);
    check("R3 bits 11:0 fixed", cfg_rdata & 32'h0000_0FFF, 32'h0);
    check("R1 upper bits loaded as zero", cfg_rdata, 32'h0);
  endtask

  task automatic t_byte_lanes();
    cfg_write(32'hFFFF_FFFF, 4'hF);
    check("R1 all ones", cfg_rdata, 32'hFFFC_0000);
    cfg_write(32'h1234_0000, 4'b1000);
    check("R5 top lane only", cfg_rdata, 32'h12FC_0000);
    cfg_write(32'h1234_0000, 4'b0100);
    check("R5 lane 2 only", cfg_rdata, 32'h1234_0000);
    cfg_write(32'hAAAA_FFFF, 4'b0011);
    check("R5 lower lanes ignored", cfg_rdata, 32'h1234_0000);
    check("R5 model agrees", cfg_rdata, model);
  endtask

  task automatic t_decode();
    lookup(1'b1, 32'h1234_0100);
    check("R7 no hit while disabled", {31'd0, hit}, 32'd0);
    set_enable(1'b1);
    lookup(1'b1, 32'h1234_0100);
    check("R8 hit inside", {31'd0, hit}, 32'd1);
    check("R8 offset inside", 32'(hit_offset), 32'h100);
    lookup(1'b1, 32'h1237_FFFF);
    check("R8 hit at top edge", {31'd0, hit}, 32'd1);
    check("R8 offset at top edge", 32'(hit_offset), 32'h3FFFF);
    lookup(1'b1, 32'h1238_0000);
    check("R8 miss above window", {31'd0, hit}, 32'd0);
    lookup(1'b1, 32'h1233_FFFC);
    check("R8 miss below window", {31'd0, hit}, 32'd0);
    lookup(1'b0, 32'h1234_0000);
    check("R7 no hit without req_valid", {31'd0, hit}, 32'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wdata = 32'h8000_0000; cfg_be = 4'hF;
    req_valid = 1'b1; req_addr = 32'h1234_0000;
    @(posedge clk);
    @(negedge clk);
    cfg_wr = 1'b0; req_valid = 1'b0;
    model = 32'h8000_0000;
    check("R9 lookup uses old base", {31'd0, hit}, 32'd1);
    check("R9 new base visible", cfg_rdata, 32'h8000_0000);
    lookup(1'b1, 32'h1234_0000);
    check("R9 old window now misses", {31'd0, hit}, 32'd0);
    lookup(1'b1, 32'h8000_0004);
    check("R8 new window hits", {31'd0, hit}, 32'd1);
    check("R8 new window offset", 32'(hit_offset), 32'h4);
  endtask

  task automatic t_disable();
    set_enable(1'b0);
    lookup(1'b1, 32'h8000_0004);
    check("R7 no hit after disable", {31'd0, hit}, 32'd0);
    do_reset();
    check("R6 readback after second reset", cfg_rdata, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_sizing();
    t_read_only();
    t_byte_lanes();
    t_decode();
    t_same_cycle();
    t_disable();
    finish_run();
  end

endmodule